// File: doc/BRIEF.md
# Secured Configuration Bit Store

This block holds the connection bits that configure a programmable logic array, kept in ordinary registers in place of nonvolatile cells. A host sends commands over a valid/ready channel. Each command carries an operation code, a bit address and one data bit. The four operations are: wipe the whole array, close one connection, read back one connection, and raise a protection flag. Every bit is driven continuously onto a configuration vector that the logic array decodes. A set bit means the connection is closed. A clear bit means it is open, and open is the wiped state.

Once the protection flag is up, the store refuses to read back or change any connection. Only a full wipe lowers the flag, and that wipe clears the whole array at the same moment. A wipe runs for a fixed number of cycles. The command channel is not ready during those cycles, and the flag stays up until the wipe completes.

All other commands answer one cycle after they are accepted. The answer is a single-cycle response strobe, an accepted/refused status and the read bit.

Top module: `cfg_store`

## Requirements
- R1: While reset is held and in the first cycle after it, all configuration bits are 0 (open), the protection flag is 0, cmdReady is 1 and rspValid is 0.
- R2: Operation code 1 (program) at an in-range address with data 1 and the flag clear closes that bit (cfgVec bit = 1). With data 0 it changes nothing. In both cases it answers rspValid=1, rspOk=1 in the cycle after acceptance. Programming never turns a 1 into a 0.
- R3: Operation code 2 (read) at an in-range address with the flag clear answers, in the cycle after acceptance, rspValid=1, rspOk=1 and rspData equal to the stored bit.
- R4: Operation code 0 (erase) drops cmdReady for exactly ERASE_CYCLES cycles after acceptance. In the first cycle cmdReady is high again, rspValid=1, rspOk=1, every bit is 0 and the flag is 0.
- R5: Operation code 3 (secure) is always accepted with rspOk=1 and sets the flag. This holds whether or not the flag is already set.
- R6: While the flag is set, program and read are refused. The response has rspOk=0 and rspData=0, and the array is left unchanged.
- R7: During an erase the flag and the array keep their values. The flag falls only at the completion of an erase.
- R8: Program or read at an address of NUM_BITS or above is refused with rspOk=0 and rspData=0, and the array is left unchanged.
- R9: While cmdReady is low, a command presented on cmdValid is not taken. It produces no response and does not alter the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Store can take a command |
| cmdOp | input | 2 | 0 erase, 1 program, 2 read, 3 secure |
| cmdAddr | input | ADDR_W | Bit address |
| cmdData | input | 1 | 1 closes the addressed connection on program |
| rspValid | output | 1 | One-cycle response strobe |
| rspOk | output | 1 | 1 accepted, 0 refused |
| rspData | output | 1 | Read-back bit, 0 unless an accepted read |
| cfgVec | output | NUM_BITS | Configuration vector to the logic array |
| locked | output | 1 | Protection flag |

## Verification
On every cycle, the assertions check the following. The array never loses a closed bit except when an erase completes. Nothing moves while the channel is busy. The flag falls only together with an erase completion. Any command that is accepted while locked or out of range is answered as refused, with zero data and an unchanged array. The exact length of the busy window is left to the bench's scenarios. So are the read-back values against a bench-side model, the effect of a command held on the channel during an erase, and re-locking after a wipe.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  typedef enum logic [1:0] {
    OP_ERASE   = 2'd0,
    OP_PROGRAM = 2'd1,
    OP_READ    = 2'd2,
    OP_SECURE  = 2'd3
  } cmdOp_e;

  typedef struct packed {
    logic closeBit;   // set the addressed connection
    logic readBit;    // capture the addressed connection
    logic setLock;    // raise the protection flag
    logic wipeDone;   // erase completes this cycle
  } strobe_t;
endpackage

// File: rtl/cfg_store_ctrl.sv
module cfg_store_ctrl
  import cfg_store_pkg::*;
#(
  parameter int NUM_BITS     = 40,
  parameter int ERASE_CYCLES = 16,
  parameter int ADDR_W       = $clog2(NUM_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              cmdData,
  input  logic              lockState,
  output logic              cmdReady,
  output strobe_t           strb,
  output logic              rspValid,
  output logic              rspOk
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             rspNext;
  logic             okNext;
  logic             addrOk;
  cmdOp_e           op;

  assign op       = cmdOp_e'(cmdOp);
  assign addrOk   = (32'(cmdAddr) < 32'(NUM_BITS));
  assign cmdReady = !busy;

  always_comb begin
    strb    = '0;
    rspNext = 1'b0;
    okNext  = 1'b0;
    if (busy) begin
      if (cnt == '0) begin
        strb.wipeDone = 1'b1;
        rspNext       = 1'b1;
        okNext        = 1'b1;
      end
    end else if (cmdValid) begin
      unique case (op)
        OP_ERASE: ;
        OP_PROGRAM: begin
          rspNext = 1'b1;
          if (!lockState && addrOk) begin
            okNext        = 1'b1;
            strb.closeBit = cmdData;
          end
        end
        OP_READ: begin
          rspNext = 1'b1;
          if (!lockState && addrOk) begin
            okNext       = 1'b1;
            strb.readBit = 1'b1;
          end
        end
        OP_SECURE: begin
          rspNext      = 1'b1;
          okNext       = 1'b1;
          strb.setLock = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cnt      <= '0;
      rspValid <= 1'b0;
      rspOk    <= 1'b0;
    end else begin
      rspValid <= rspNext;
      rspOk    <= okNext;
      if (!busy && cmdValid && op == OP_ERASE) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(ERASE_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_store_dp.sv
module cfg_store_dp
  import cfg_store_pkg::*;
#(
  parameter int NUM_BITS = 40,
  parameter int ADDR_W   = $clog2(NUM_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [ADDR_W-1:0]   cmdAddr,
  output logic [NUM_BITS-1:0] bits,
  output logic                lockState,
  output logic                rdBit
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bits      <= '0;
      lockState <= 1'b0;
      rdBit     <= 1'b0;
    end else begin
      rdBit <= strb.readBit ? bits[cmdAddr] : 1'b0;
      if (strb.wipeDone) begin
        bits      <= '0;
        lockState <= 1'b0;
      end else begin
        if (strb.closeBit) bits[cmdAddr] <= 1'b1;
        if (strb.setLock)  lockState     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_store_pkg::*;
#(
  parameter int NUM_BITS     = 40,
  parameter int ERASE_CYCLES = 16,
  parameter int ADDR_W       = $clog2(NUM_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  output logic                cmdReady,
  input  logic [1:0]          cmdOp,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic                cmdData,
  output logic                rspValid,
  output logic                rspOk,
  output logic                rspData,
  output logic [NUM_BITS-1:0] cfgVec,
  output logic                locked
);
  strobe_t strb;
  logic    lockState;

  cfg_store_ctrl #(.NUM_BITS(NUM_BITS), .ERASE_CYCLES(ERASE_CYCLES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .lockState(lockState), .cmdReady(cmdReady), .strb(strb),
    .rspValid(rspValid), .rspOk(rspOk)
  );

  cfg_store_dp #(.NUM_BITS(NUM_BITS), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdAddr(cmdAddr),
    .bits(cfgVec), .lockState(lockState), .rdBit(rspData)
  );

  assign locked = lockState;
endmodule

// File: rtl/cfg_store_chk.sv
module cfg_store_chk #(
  parameter int NUM_BITS = 40,
  parameter int ADDR_W   = $clog2(NUM_BITS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic                cmdReady,
  input logic [1:0]          cmdOp,
  input logic [ADDR_W-1:0]   cmdAddr,
  input logic                rspValid,
  input logic                rspOk,
  input logic                rspData,
  input logic [NUM_BITS-1:0] cfgVec,
  input logic                locked
);
  logic takeAccess;
  logic wipeAck;
  assign takeAccess = cmdValid && cmdReady && (cmdOp == 2'd1 || cmdOp == 2'd2);
  assign wipeAck    = rspValid && rspOk && cfgVec == '0 && !locked;

  AST_BUSY_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady && cmdOp == 2'd0 |=> !cmdReady); // R4
  AST_ONLY_ERASE_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(cfgVec) & ~cfgVec)) |-> wipeAck && $past(!cmdReady)); // R2
  AST_LOCKED_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    takeAccess && locked |=> rspValid && !rspOk && !rspData && $stable(cfgVec)); // R6
  AST_RANGE_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    takeAccess && 32'(cmdAddr) >= 32'(NUM_BITS) |=> rspValid && !rspOk && !rspData && $stable(cfgVec)); // R8
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !cmdReady |-> $stable(cfgVec) && $stable(locked) && !rspValid); // R7
  AST_UNLOCK_ON_WIPE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> wipeAck && $past(!cmdReady)); // R7
  AST_SECURE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady && cmdOp == 2'd3 |=> rspValid && rspOk && locked); // R5
endmodule

bind cfg_store cfg_store_chk #(.NUM_BITS(NUM_BITS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
  .cmdAddr(cmdAddr), .rspValid(rspValid), .rspOk(rspOk), .rspData(rspData),
  .cfgVec(cfgVec), .locked(locked)
);

// File: tb/cfg_store_bench.sv
module cfg_store_bench;
  localparam int NB = 40;
  localparam int EC = 16;
  localparam int AW = $clog2(NB);
  localparam int NV = 13;
  // fields: [10:9] op, [8:3] addr, [2] data, [1] expected ok, [0] expected read bit
  localparam logic [10:0] VEC [NV] = '{
    {2'd1, 6'd3,  1'b1, 1'b1, 1'b0},   // R2 close 3
    {2'd2, 6'd3,  1'b0, 1'b1, 1'b1},   // R3 read 3
    {2'd2, 6'd4,  1'b0, 1'b1, 1'b0},   // R3 read open bit
    {2'd1, 6'd4,  1'b0, 1'b1, 1'b0},   // R2 data 0 no change
    {2'd2, 6'd4,  1'b0, 1'b1, 1'b0},   // R2 still open
    {2'd1, 6'd39, 1'b1, 1'b1, 1'b0},   // R2 top bit
    {2'd2, 6'd39, 1'b0, 1'b1, 1'b1},   // R3
    {2'd1, 6'd40, 1'b1, 1'b0, 1'b0},   // R8 out of range
    {2'd2, 6'd45, 1'b0, 1'b0, 1'b0},   // R8
    {2'd3, 6'd0,  1'b0, 1'b1, 1'b0},   // R5 secure
    {2'd2, 6'd3,  1'b0, 1'b0, 1'b0},   // R6 read refused
    {2'd1, 6'd5,  1'b1, 1'b0, 1'b0},   // R6 program refused
    {2'd3, 6'd0,  1'b0, 1'b1, 1'b0}    // R5 secure again
  };

  logic clk = 1'b0;
  logic rstN, cmdValid, cmdReady, cmdData, rspValid, rspOk, rspData, locked;
  logic [1:0] cmdOp;
  logic [AW-1:0] cmdAddr;
  logic [NB-1:0] cfgVec;
  logic [NB-1:0] model;
  logic modelLock;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cfg_store #(.NUM_BITS(NB), .ERASE_CYCLES(EC)) u_cfg_store (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .rspValid(rspValid), .rspOk(rspOk),
    .rspData(rspData), .cfgVec(cfgVec), .locked(locked)
  );

  task automatic chk(input bit cond, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doCmd(input logic [1:0] op, input int addr, input logic d,
                       input logic expOk, input logic expRd, input string req);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = AW'(addr); cmdData = d;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    chk(rspValid === 1'b1, req, 64'(rspValid), 64'd1);
    chk(rspOk === expOk, req, 64'(rspOk), 64'(expOk));
    chk(rspData === expRd, req, 64'(rspData), 64'(expRd));
    if (op == 2'd1 && expOk && d) model[addr] = 1'b1;
    if (op == 2'd3) modelLock = 1'b1;
    chk(cfgVec === model, req, 64'(cfgVec), 64'(model));
    chk(locked === modelLock, req, 64'(locked), 64'(modelLock));
  endtask

  task automatic doErase(input bit intrude);
    logic [NB-1:0] vecBefore;
    logic lockBefore;
    int n;
    vecBefore = cfgVec; lockBefore = locked;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd0;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    n = 0;
    while (!cmdReady && n < 100) begin
      chk(locked === lockBefore, "R7 lock held", 64'(locked), 64'(lockBefore));
      chk(cfgVec === vecBefore, "R7 array held", 64'(cfgVec), 64'(vecBefore));
      chk(!rspValid, "R9 no response while busy", 64'(rspValid), 64'd0);
      if (intrude && n == 2) begin
        cmdValid = 1'b1; cmdOp = 2'd1; cmdAddr = AW'(10); cmdData = 1'b1;
      end
      if (intrude && n == 5) cmdValid = 1'b0;
      n++;
      @(negedge clk);
    end
    chk(n == EC, "R4 busy length", 64'(n), 64'(EC));
    chk(rspValid && rspOk, "R4 completion response", 64'({rspValid, rspOk}), 64'd3);
    chk(cfgVec === '0, "R4 array wiped", 64'(cfgVec), 64'd0);
    chk(locked === 1'b0, "R4 lock cleared", 64'(locked), 64'd0);
    model = '0; modelLock = 1'b0;
    @(negedge clk);
    chk(!rspValid, "R9 stray command not taken", 64'(rspValid), 64'd0);
    chk(cfgVec[10] === 1'b0, "R9 held command had no effect", 64'(cfgVec[10]), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = '0; cmdAddr = '0; cmdData = 1'b0;
    model = '0; modelLock = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cfgVec === '0 && !locked, "R1 reset state held", 64'(cfgVec), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(cmdReady === 1'b1, "R1 ready", 64'(cmdReady), 64'd1);
    chk(rspValid === 1'b0, "R1 no response", 64'(rspValid), 64'd0);
    chk(cfgVec === '0, "R1 array open", 64'(cfgVec), 64'd0);
    chk(locked === 1'b0, "R1 unlocked", 64'(locked), 64'd0);

    for (int i = 0; i < NV; i++)
      doCmd(VEC[i][10:9], int'(VEC[i][8:3]), VEC[i][2], VEC[i][1], VEC[i][0],
            $sformatf("R2/R3/R5/R6/R8 vector %0d", i));

    doErase(1'b1);                                        // R4 R7 R9
    doCmd(2'd1, 7, 1'b1, 1'b1, 1'b0, "R2 program after wipe");
    doCmd(2'd2, 7, 1'b0, 1'b1, 1'b1, "R3 read after wipe");
    doCmd(2'd2, 3, 1'b0, 1'b1, 1'b0, "R4 old bit gone");
    doCmd(2'd3, 0, 1'b0, 1'b1, 1'b0, "R5 later secure");
    doCmd(2'd2, 7, 1'b0, 1'b0, 1'b0, "R6 read refused");
    doErase(1'b0);                                        // R4 R7
    doCmd(2'd2, 7, 1'b0, 1'b1, 1'b0, "R4 unlocked and wiped");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule